// File: doc/BRIEF.md
# Block-Error Second Performance Monitor

This block grades each one-second interval of a digital signal from the block checks made within it. A strobe reports each checked block and whether it was errored, and a level input reports a defect. At every one-second tick the interval that just ended is graded as clean, errored or severely errored. The grade feeds five performance counters: errored seconds, severely errored seconds, background block errors, unavailable seconds and consecutive severely errored runs.

The counters follow an availability state. Ten severely errored seconds in a row make the signal unavailable, starting from the first of the ten. Ten seconds in a row that are not severely errored make it available again, also starting from the first of the ten. Since the state change applies to seconds that are already over, the increments for a run still in progress are held as pending values. They are then added to the counters, or added to the unavailable count, once the run is decided. A synchronous clear puts every counter to zero and returns the block to the available state.

Top module: `perf_second_mon`

## Requirements
- R1: A second that contains at least one errored block, or that is severely errored, adds one to `es_cnt_o` when its increments are committed in the available state.
- R2: A second is severely errored when `defect_i` is high in any cycle of it, including its closing tick cycle, or when it has at least one block and ten times its errored blocks is at least three times its blocks. 3 errored of 10 is severe; 3 of 11 is not. A severe second adds one to `ses_cnt_o` when committed.
- R3: `bbe_cnt_o` grows by the errored-block count of each committed second that is not severely errored. Errored blocks inside a severe second are never added.
- R4: A second closes in the cycle where `sec_tick_i` is high. A block strobed in that cycle belongs to the closing second. The counters and `unavail_o` change only in the cycle after a closing tick or a clear, and keep their values otherwise.
- R5: The tenth severely errored second of a run in the available state sets `unavail_o`. It adds ten to `uas_cnt_o` and drops the held ES and SES increments of those ten seconds.
- R6: While `unavail_o` is high, ES, SES and BBE do not change. A severely errored second adds to `uas_cnt_o` one, plus the number of non-severe seconds that came just before it in the pending run.
- R7: While unavailable, the tenth non-severe second in a row clears `unavail_o`. The held ES and BBE increments of those ten seconds are then added to the counters.
- R8: In the available state, a run of 2 to 9 severely errored seconds that is ended by a non-severe second adds one to `cses_cnt_o` and commits its held increments. A run of length 1 commits without touching `cses_cnt_o`.
- R9: With `clr_i` high at a clock edge, all counters read zero and `unavail_o` reads low in the next cycle. The partly collected second is discarded.
- R10: After reset all counters read zero and `unavail_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of counters and state |
| sec_tick_i | input | 1 | One-cycle pulse that closes the current second |
| blk_valid_i | input | 1 | One block checked in this cycle |
| blk_err_i | input | 1 | The block strobed in this cycle was errored |
| defect_i | input | 1 | Defect present in this cycle |
| es_cnt_o | output | CNT_W | Errored-second count |
| ses_cnt_o | output | CNT_W | Severely errored second count |
| bbe_cnt_o | output | CNT_W | Background block error count |
| uas_cnt_o | output | CNT_W | Unavailable second count |
| cses_cnt_o | output | CNT_W | Consecutive severe run count |
| unavail_o | output | 1 | Unavailable state |

## Verification
Each result is due exactly one cycle after the tick cycle that closes its second, or one cycle after a clear. The bench drives on falling edges and compares every output on the falling edge that follows the tick. Results that depend on a run of seconds arrive only with the tick of the second that decides the run. The bench therefore checks that the counters stay unchanged through the undecided seconds before it checks the retroactive jump. A separate check strobes errored blocks with no tick and confirms that nothing moves.

// File: rtl/pm_mon_pkg.sv
package pm_mon_pkg;
    // Grade of a closed second
    typedef struct packed {
        logic errored;
        logic severe;
    } sec_class_t;
endpackage

// File: rtl/pm_sec_accum.sv
module pm_sec_accum
    import pm_mon_pkg::*;
#(
    parameter int BLK_W   = 16,
    parameter int SES_NUM = 3,
    parameter int SES_DEN = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             blk_valid_i,
    input  logic             blk_err_i,
    input  logic             defect_i,
    output logic             close_o,
    output sec_class_t       cls_o,
    output logic [BLK_W-1:0] bbe_add_o
);
    localparam int PW = BLK_W + 8;

    typedef struct packed {
        logic [BLK_W-1:0] nblk;
        logic [BLK_W-1:0] nerr;
        logic             dfct;
    } acc_t;

    acc_t             acc_d, acc_q;
    logic [BLK_W-1:0] tot_blk, tot_err;
    logic             dfct_all;
    logic [PW-1:0]    lhs, rhs;

    always_comb begin
        tot_blk  = (acc_q.nblk == '1) ? acc_q.nblk : acc_q.nblk + BLK_W'(blk_valid_i);
        tot_err  = (acc_q.nerr == '1) ? acc_q.nerr
                                      : acc_q.nerr + BLK_W'(blk_valid_i & blk_err_i);
        dfct_all = acc_q.dfct | defect_i;
        // integer form of the 30 percent test
        lhs = PW'(tot_err) * PW'(SES_DEN);
        rhs = PW'(tot_blk) * PW'(SES_NUM);

        cls_o.severe  = dfct_all | ((tot_blk != '0) && (lhs >= rhs));
        cls_o.errored = (tot_err != '0) | cls_o.severe;
        bbe_add_o     = cls_o.severe ? '0 : tot_err;
        close_o       = tick_i & ~clr_i;

        acc_d.nblk = tot_blk;
        acc_d.nerr = tot_err;
        acc_d.dfct = dfct_all;
        if (clr_i || tick_i) begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_d;
    end

    // R2: a defect seen in the closing cycle forces a severe grade
    a_r2_defect_severe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (close_o && defect_i) |-> cls_o.severe);
    // R3: severe seconds never contribute background errors
    a_r3_no_bbe_in_ses: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (close_o && acc_q.dfct) |-> (bbe_add_o == '0));
endmodule

// File: rtl/pm_avail_tracker.sv
module pm_avail_tracker
    import pm_mon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BLK_W   = 16,
    parameter int RUN_LEN = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             close_i,
    input  sec_class_t       cls_i,
    input  logic [BLK_W-1:0] bbe_add_i,
    output logic [CNT_W-1:0] es_o,
    output logic [CNT_W-1:0] ses_o,
    output logic [CNT_W-1:0] bbe_o,
    output logic [CNT_W-1:0] uas_o,
    output logic [CNT_W-1:0] cses_o,
    output logic             unavail_o
);
    localparam int             RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

    typedef struct packed {
        logic             unavail;
        logic [RUN_W-1:0] run;
        logic [RUN_W-1:0] p_es;
        logic [RUN_W-1:0] p_ses;
        logic [CNT_W-1:0] p_bbe;
        logic [CNT_W-1:0] es;
        logic [CNT_W-1:0] ses;
        logic [CNT_W-1:0] bbe;
        logic [CNT_W-1:0] uas;
        logic [CNT_W-1:0] cses;
    } trk_t;

    trk_t s_d, s_q;
    logic exit_now;

    always_comb begin
        s_d      = s_q;
        exit_now = close_i && s_q.unavail && !cls_i.severe && (s_q.run == LAST);
        if (clr_i) begin
            s_d = '0;
        end else if (close_i) begin
            if (!s_q.unavail) begin
                if (cls_i.severe) begin
                    if (s_q.run == LAST) begin
                        // run reached its length: all of it becomes unavailable
                        s_d.unavail = 1'b1;
                        s_d.uas     = s_q.uas + CNT_W'(RUN_LEN);
                        s_d.run     = '0;
                        s_d.p_es    = '0;
                        s_d.p_ses   = '0;
                        s_d.p_bbe   = '0;
                    end else begin
                        s_d.run   = s_q.run + 1'b1;
                        s_d.p_es  = s_q.p_es + RUN_W'(cls_i.errored);
                        s_d.p_ses = s_q.p_ses + 1'b1;
                        s_d.p_bbe = s_q.p_bbe + CNT_W'(bbe_add_i);
                    end
                end else begin
                    s_d.es    = s_q.es + CNT_W'(s_q.p_es) + CNT_W'(cls_i.errored);
                    s_d.ses   = s_q.ses + CNT_W'(s_q.p_ses);
                    s_d.bbe   = s_q.bbe + s_q.p_bbe + CNT_W'(bbe_add_i);
                    if (s_q.run >= RUN_W'(2)) s_d.cses = s_q.cses + 1'b1;
                    s_d.run   = '0;
                    s_d.p_es  = '0;
                    s_d.p_ses = '0;
                    s_d.p_bbe = '0;
                end
            end else begin
                if (cls_i.severe) begin
                    // broken recovery run: held seconds stay unavailable
                    s_d.uas   = s_q.uas + CNT_W'(s_q.run) + CNT_W'(1);
                    s_d.run   = '0;
                    s_d.p_es  = '0;
                    s_d.p_bbe = '0;
                end else if (s_q.run == LAST) begin
                    s_d.unavail = 1'b0;
                    s_d.es      = s_q.es + CNT_W'(s_q.p_es) + CNT_W'(cls_i.errored);
                    s_d.bbe     = s_q.bbe + s_q.p_bbe + CNT_W'(bbe_add_i);
                    s_d.run     = '0;
                    s_d.p_es    = '0;
                    s_d.p_bbe   = '0;
                end else begin
                    s_d.run   = s_q.run + 1'b1;
                    s_d.p_es  = s_q.p_es + RUN_W'(cls_i.errored);
                    s_d.p_bbe = s_q.p_bbe + CNT_W'(bbe_add_i);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign es_o      = s_q.es;
    assign ses_o     = s_q.ses;
    assign bbe_o     = s_q.bbe;
    assign uas_o     = s_q.uas;
    assign cses_o    = s_q.cses;
    assign unavail_o = s_q.unavail;

    // R4: nothing moves without a closing tick or a clear
    a_r4_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!close_i && !clr_i) |=> ($stable(s_q.es) && $stable(s_q.ses) && $stable(s_q.bbe)
                                  && $stable(s_q.uas) && $stable(s_q.cses) && $stable(s_q.unavail)));
    // R5: entering unavailability charges a whole run
    a_r5_entry_uas: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.unavail) |-> (s_q.uas == $past(s_q.uas) + CNT_W'(RUN_LEN)));
    // R5: a pending run never reaches its full length
    a_r5_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.run < RUN_W'(RUN_LEN));
    // R6: errored counters frozen while unavailable
    a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.unavail && !clr_i && !exit_now) |=> ($stable(s_q.es) && $stable(s_q.ses) && $stable(s_q.bbe)));
    // R8: consecutive-run counter steps by at most one
    a_r8_cses_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((s_q.cses == $past(s_q.cses)) || (s_q.cses == $past(s_q.cses) + 1'b1)));
    // R9: clear empties everything
    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> ((s_q.es == '0) && (s_q.uas == '0) && (s_q.cses == '0) && !s_q.unavail));
endmodule

// File: rtl/perf_second_mon.sv
module perf_second_mon
    import pm_mon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BLK_W   = 16,
    parameter int RUN_LEN = 10,
    parameter int SES_NUM = 3,
    parameter int SES_DEN = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             sec_tick_i,
    input  logic             blk_valid_i,
    input  logic             blk_err_i,
    input  logic             defect_i,
    output logic [CNT_W-1:0] es_cnt_o,
    output logic [CNT_W-1:0] ses_cnt_o,
    output logic [CNT_W-1:0] bbe_cnt_o,
    output logic [CNT_W-1:0] uas_cnt_o,
    output logic [CNT_W-1:0] cses_cnt_o,
    output logic             unavail_o
);
    logic             close_w;
    sec_class_t       cls_w;
    logic [BLK_W-1:0] bbe_add_w;

    pm_sec_accum #(
        .BLK_W  (BLK_W),
        .SES_NUM(SES_NUM),
        .SES_DEN(SES_DEN)
    ) accum_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (clr_i),
        .tick_i     (sec_tick_i),
        .blk_valid_i(blk_valid_i),
        .blk_err_i  (blk_err_i),
        .defect_i   (defect_i),
        .close_o    (close_w),
        .cls_o      (cls_w),
        .bbe_add_o  (bbe_add_w)
    );

    pm_avail_tracker #(
        .CNT_W  (CNT_W),
        .BLK_W  (BLK_W),
        .RUN_LEN(RUN_LEN)
    ) trk_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr_i),
        .close_i  (close_w),
        .cls_i    (cls_w),
        .bbe_add_i(bbe_add_w),
        .es_o     (es_cnt_o),
        .ses_o    (ses_cnt_o),
        .bbe_o    (bbe_cnt_o),
        .uas_o    (uas_cnt_o),
        .cses_o   (cses_cnt_o),
        .unavail_o(unavail_o)
    );
endmodule

// File: tb/perf_second_mon_tb_top.sv
module perf_second_mon_tb_top;
    localparam int CNT_W = 32;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic clr = 1'b0, tick = 1'b0, bv = 1'b0, be = 1'b0, dft = 1'b0;
    logic [CNT_W-1:0] es, ses, bbe, uas, cses;
    logic unav;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    perf_second_mon dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .sec_tick_i(tick),
        .blk_valid_i(bv), .blk_err_i(be), .defect_i(dft),
        .es_cnt_o(es), .ses_cnt_o(ses), .bbe_cnt_o(bbe), .uas_cnt_o(uas),
        .cses_cnt_o(cses), .unavail_o(unav)
    );

    typedef struct packed {
        logic [7:0] nb, ne; logic df;
        logic [7:0] es, ses, bbe, uas, cses; logic un;
    } vec_t;

    // one row per second: blocks, errored blocks, defect, then expected outputs
    // rows 2-4: R1 R3; 5-6: R2 R1; 7-9: R8; 10-19: R5; 20-21: R6; 22-31: R7; 32-34: R8
    localparam vec_t VEC [34] = '{
        '{8'd10, 8'd0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0},
        '{8'd10, 8'd1, 1'b0, 8'd1, 8'd0, 8'd1, 8'd0, 8'd0, 1'b0},
        '{8'd10, 8'd2, 1'b0, 8'd2, 8'd0, 8'd3, 8'd0, 8'd0, 1'b0},
        '{8'd11, 8'd3, 1'b0, 8'd3, 8'd0, 8'd6, 8'd0, 8'd0, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd3, 8'd0, 8'd6, 8'd0, 8'd0, 1'b0},
        '{8'd10, 8'd0, 1'b0, 8'd4, 8'd1, 8'd6, 8'd0, 8'd0, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd4, 8'd1, 8'd6, 8'd0, 8'd0, 1'b0},
        '{8'd0,  8'd0, 1'b1, 8'd4, 8'd1, 8'd6, 8'd0, 8'd0, 1'b0},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd0,  8'd0, 1'b1, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd0,  8'd0, 1'b1, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd0,  8'd0, 1'b1, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd0,  8'd0, 1'b1, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd7, 8'd3, 8'd7, 8'd0, 8'd1, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd7, 8'd3, 8'd7, 8'd10, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd10, 8'd1, 1'b1},
        '{8'd10, 8'd3, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd7, 8'd3, 8'd7, 8'd12, 8'd1, 1'b1},
        '{8'd10, 8'd1, 1'b0, 8'd17, 8'd3, 8'd17, 8'd12, 8'd1, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd17, 8'd3, 8'd17, 8'd12, 8'd1, 1'b0},
        '{8'd10, 8'd3, 1'b0, 8'd17, 8'd3, 8'd17, 8'd12, 8'd1, 1'b0},
        '{8'd10, 8'd0, 1'b0, 8'd19, 8'd5, 8'd17, 8'd12, 8'd2, 1'b0}
    };

    task automatic check(string tag, logic [40:0] act, logic [40:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [40:0] snap();
        return {es[7:0], ses[7:0], bbe[7:0], uas[7:0], cses[7:0], unav};
    endfunction

    // one second of traffic; the result is due one cycle after the tick cycle
    task automatic one_second(int nb, int ne, bit df);
        dft = df;
        for (int k = 0; k < nb; k++) begin
            @(negedge clk); bv = 1'b1; be = (k < ne);
        end
        @(negedge clk); bv = 1'b0; be = 1'b0; tick = 1'b1;
        @(negedge clk); tick = 1'b0; dft = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", snap(), '0);
        rst_ni = 1'b1;
        @(negedge clk);

        // vector walk: R1 R2 R3 R5 R6 R7 R8
        for (int i = 0; i < 34; i++) begin
            one_second(int'(VEC[i].nb), int'(VEC[i].ne), VEC[i].df);
            check($sformatf("R1/R2/R3/R5/R6/R7/R8 second %0d", i + 1), snap(),
                  {VEC[i].es, VEC[i].ses, VEC[i].bbe, VEC[i].uas, VEC[i].cses, VEC[i].un});
        end

        // R4: errored blocks and a defect with no tick leave outputs unchanged
        dft = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); bv = 1'b1; be = 1'b1;
        end
        @(negedge clk); bv = 1'b0; be = 1'b0; dft = 1'b0;
        @(negedge clk);
        check("R4 no tick no change", snap(), {8'd19, 8'd5, 8'd17, 8'd12, 8'd2, 1'b0});

        // R9: clear drops counters and the partly collected severe second
        do_clear();
        check("R9 clear zeros", snap(), '0);
        one_second(10, 0, 1'b0);
        check("R9 partial second discarded", snap(), '0);

        // R2: one-cycle defect inside an otherwise clean second
        @(negedge clk); dft = 1'b1;
        @(negedge clk); dft = 1'b0;
        one_second(10, 0, 1'b0);
        one_second(10, 0, 1'b0);
        check("R2 short defect makes severe", snap(), {8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 1'b0});

        // R2: defect seen only in the tick cycle
        one_second(0, 0, 1'b0);
        dft = 1'b0;
        @(negedge clk); tick = 1'b1; dft = 1'b1;
        @(negedge clk); tick = 1'b0; dft = 1'b0;
        one_second(10, 0, 1'b0);
        check("R2 defect in tick cycle", snap(), {8'd2, 8'd2, 8'd0, 8'd0, 8'd0, 1'b0});

        // R4: block strobed in the tick cycle belongs to the closing second
        @(negedge clk); tick = 1'b1; bv = 1'b1; be = 1'b1;
        @(negedge clk); tick = 1'b0; bv = 1'b0; be = 1'b0;
        check("R4 tick-cycle block counted", snap(), {8'd2, 8'd2, 8'd0, 8'd0, 8'd0, 1'b0});
        one_second(10, 0, 1'b0);
        check("R4 tick-cycle block committed", snap(), {8'd3, 8'd3, 8'd0, 8'd0, 8'd0, 1'b0});

        // R5 then R9: enter unavailability by defects, then clear returns to available
        for (int s = 0; s < 10; s++) one_second(0, 0, 1'b1);
        check("R5 entry by defects", snap(), {8'd3, 8'd3, 8'd0, 8'd10, 8'd0, 1'b1});
        do_clear();
        check("R9 clear leaves unavailable", snap(), '0);

        // R1: zero-block clean second counts nothing
        one_second(0, 0, 1'b0);
        check("R1 empty second clean", snap(), '0);

        done = 1'b1;
        finish_run();
    end
endmodule